// File: doc/BRIEF.md
# Line threshold interrupt controller

The block gathers a set of event sources into one shared interrupt pin. Each source has a sticky flag. A flag is set by a one-cycle event pulse and stays set until software clears it with a write-one-to-clear strobe. A per-source enable decides which flags can drive the pin. With interrupts turned off, the pin goes back to its ordinary push-pull function and carries a pass-through value. With interrupts turned on, the pin acts as an open-drain output. It drives the selected active level while any enabled flag is set and releases the line otherwise.

The top flag is driven by a line measurement threshold detector. A select bit chooses either the signed voltage sample or the signed current sample. The detector takes the magnitude of that sample, saturating -128 to 127, and compares it with an unsigned 8-bit threshold. The detector is a three-state machine: `ST_VOID`, `ST_UNDER` and `ST_OVER`. `ST_VOID` means no sample has been seen since reset. `ST_UNDER` means the last magnitude was at or below the threshold, and `ST_OVER` means it was above.

The state machine moves only on a sample-valid strobe:
- `ST_VOID` goes to `ST_UNDER` or `ST_OVER` with no event.
- `ST_UNDER` goes to `ST_OVER` as an upward crossing.
- `ST_OVER` goes to `ST_UNDER` as a downward crossing.
- Otherwise the state holds, with no event.

A direction bit decides which kind of crossing raises the event.

Top module: `line_irq_ctrl`

## Requirements
- R1: After reset all flags read 0 and the detector is in `ST_VOID`.
- R2: A pulse on `evt_i[k]` sets `flags_o[k]` at the next clock edge, whatever the value of `src_en_i[k]`.
- R3: A set flag stays set until a cycle with `clr_we_i`=1 and `clr_mask_i[k]`=1. Mask bits that are 0, and masks presented while `clr_we_i`=0, leave flags unchanged.
- R4: When an event for bit k and a clear of bit k occur in the same cycle, the flag is set after the edge.
- R5: With `irq_en_i`=0, `pin_oe_o`=1 and `pin_o` equals `alt_out_i`. Flags still collect events in this mode.
- R6: With `irq_en_i`=1, `pin_oe_o`=1 and `pin_o`=`irq_pol_i` while any flag with its enable bit set is 1, and `pin_oe_o`=0 otherwise. `irq_pol_i`=0 means active low and 1 means active high.
- R7: `src_sel_i`=0 selects `volt_smp_i` and 1 selects `curr_smp_i`. Both are 8-bit two's complement samples. The compared magnitude is |sample|, with -128 read as 127. The sample is "over" when the magnitude is strictly greater than `thr_i`.
- R8: With `dir_fall_i`=0, the threshold flag, at bit `NUM_EXT` (bit 6 by default), is set only on a strobe that moves the state from `ST_UNDER` to `ST_OVER`.
- R9: With `dir_fall_i`=1, the threshold flag is set only on a strobe that moves the state from `ST_OVER` to `ST_UNDER`.
- R10: No threshold event occurs on the first strobe after reset, on a strobe that keeps the same state, or in a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EXT | One-cycle event pulses of the external sources |
| smp_vld_i | input | 1 | Strobe marking new measurement samples |
| volt_smp_i | input | SMP_W | Signed line voltage sample |
| curr_smp_i | input | SMP_W | Signed line current sample |
| src_sel_i | input | 1 | 0 compares voltage, 1 compares current |
| thr_i | input | THR_W | Unsigned threshold |
| dir_fall_i | input | 1 | 0 fires on upward crossing, 1 on downward crossing |
| src_en_i | input | NUM_EXT+1 | Per-source enable for the pin |
| irq_en_i | input | 1 | Puts the pin in interrupt mode |
| irq_pol_i | input | 1 | Active level of the interrupt pin |
| alt_out_i | input | 1 | Value driven on the pin when not in interrupt mode |
| clr_we_i | input | 1 | Flag clear write strobe |
| clr_mask_i | input | NUM_EXT+1 | Write-one-to-clear mask |
| flags_o | output | NUM_EXT+1 | Sticky flags |
| pin_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
Event pulses, clears and sample strobes are registered once, so their effect on `flags_o` is due one clock edge after the cycle in which they are presented. The pin is a combinational function of the flags and the configuration bits. It therefore changes in the same cycle as the flags, or immediately after a configuration change. The bench changes inputs at the falling edge and compares outputs at the following falling edge, so exactly one rising edge lies between a stimulus and its check. Each crossing case runs from a known detector state that the previous strobe put in place.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
    typedef enum logic [1:0] {
        ST_VOID  = 2'd0,
        ST_UNDER = 2'd1,
        ST_OVER  = 2'd2
    } lvl_state_t;
endpackage

// File: rtl/line_mag.sv
module line_mag #(
    parameter int SMP_W = 8
) (
    input  logic             sel_i,
    input  logic [SMP_W-1:0] volt_i,
    input  logic [SMP_W-1:0] curr_i,
    output logic [SMP_W-1:0] mag_o
);
    localparam logic [SMP_W-1:0] MOST_NEG = {1'b1, {(SMP_W-1){1'b0}}};
    localparam logic [SMP_W-1:0] MOST_POS = {1'b0, {(SMP_W-1){1'b1}}};

    logic [SMP_W-1:0] pick;

    always_comb begin
        pick = sel_i ? curr_i : volt_i;
        if (pick == MOST_NEG)
            mag_o = MOST_POS;
        else if (pick[SMP_W-1])
            mag_o = ~pick + 1'b1;
        else
            mag_o = pick;
    end
endmodule

// File: rtl/line_xing_det.sv
module line_xing_det
    import line_irq_pkg::*;
#(
    parameter int SMP_W = 8,
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [SMP_W-1:0] mag_i,
    input  logic [THR_W-1:0] thr_i,
    input  logic             dir_fall_i,
    output logic             xing_o
);
    localparam int CMP_W = (SMP_W > THR_W) ? SMP_W : THR_W;

    lvl_state_t state_q, state_d;
    logic       over;

    assign over = CMP_W'(mag_i) > CMP_W'(thr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_VOID;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        xing_o  = 1'b0;
        if (vld_i) begin
            unique case (state_q)
                ST_VOID: begin
                    state_d = over ? ST_OVER : ST_UNDER;
                end
                ST_UNDER: begin
                    if (over) begin
                        state_d = ST_OVER;
                        xing_o  = !dir_fall_i;
                    end
                end
                ST_OVER: begin
                    if (!over) begin
                        state_d = ST_UNDER;
                        xing_o  = dir_fall_i;
                    end
                end
                default: begin
                    state_d = ST_VOID;
                end
            endcase
        end
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               clr_we_i,
    input  logic [NUM_SRC-1:0] clr_mask_i,
    output logic [NUM_SRC-1:0] flags_o
);
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags_o[k] <= 1'b0;
            else if (set_i[k])
                flags_o[k] <= 1'b1;
            else if (clr_we_i && clr_mask_i[k])
                flags_o[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
    parameter int NUM_SRC = 7
) (
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               irq_en_i,
    input  logic               irq_pol_i,
    input  logic               alt_out_i,
    output logic               pin_o,
    output logic               pin_oe_o
);
    logic pending;

    always_comb begin
        pending = |(flags_i & en_i);
        if (irq_en_i) begin
            pin_o    = irq_pol_i;
            pin_oe_o = pending;
        end else begin
            pin_o    = alt_out_i;
            pin_oe_o = 1'b1;
        end
    end
endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl #(
    parameter int NUM_EXT = 6,
    parameter int SMP_W   = 8,
    parameter int THR_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EXT-1:0]   evt_i,
    input  logic                 smp_vld_i,
    input  logic [SMP_W-1:0]     volt_smp_i,
    input  logic [SMP_W-1:0]     curr_smp_i,
    input  logic                 src_sel_i,
    input  logic [THR_W-1:0]     thr_i,
    input  logic                 dir_fall_i,
    input  logic [NUM_EXT:0]     src_en_i,
    input  logic                 irq_en_i,
    input  logic                 irq_pol_i,
    input  logic                 alt_out_i,
    input  logic                 clr_we_i,
    input  logic [NUM_EXT:0]     clr_mask_i,
    output logic [NUM_EXT:0]     flags_o,
    output logic                 pin_o,
    output logic                 pin_oe_o
);
    localparam int NUM_SRC = NUM_EXT + 1;

    logic [SMP_W-1:0]   mag;
    logic               xing_evt;
    logic [NUM_SRC-1:0] set_vec;

    line_mag #(.SMP_W(SMP_W)) i_mag (
        .sel_i  (src_sel_i),
        .volt_i (volt_smp_i),
        .curr_i (curr_smp_i),
        .mag_o  (mag)
    );

    line_xing_det #(.SMP_W(SMP_W), .THR_W(THR_W)) i_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (smp_vld_i),
        .mag_i      (mag),
        .thr_i      (thr_i),
        .dir_fall_i (dir_fall_i),
        .xing_o     (xing_evt)
    );

    assign set_vec = {xing_evt, evt_i};

    irq_flag_bank #(.NUM_SRC(NUM_SRC)) i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (clr_mask_i),
        .flags_o    (flags_o)
    );

    irq_pin_drv #(.NUM_SRC(NUM_SRC)) i_pin (
        .flags_i   (flags_o),
        .en_i      (src_en_i),
        .irq_en_i  (irq_en_i),
        .irq_pol_i (irq_pol_i),
        .alt_out_i (alt_out_i),
        .pin_o     (pin_o),
        .pin_oe_o  (pin_oe_o)
    );
endmodule

// File: rtl/line_irq_chk.sv
module line_irq_chk #(
    parameter int NUM_EXT = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EXT-1:0] evt_i,
    input logic               smp_vld_i,
    input logic               xing_evt,
    input logic [NUM_EXT:0]   src_en_i,
    input logic               irq_en_i,
    input logic               irq_pol_i,
    input logic               alt_out_i,
    input logic               clr_we_i,
    input logic [NUM_EXT:0]   clr_mask_i,
    input logic [NUM_EXT:0]   flags_o,
    input logic               pin_o,
    input logic               pin_oe_o
);
    logic [NUM_EXT:0] clr_v, set_v, keep_v, drop_v;

    assign clr_v  = clr_we_i ? clr_mask_i : '0;
    assign set_v  = {xing_evt, evt_i};
    assign keep_v = flags_o & ~clr_v;
    assign drop_v = clr_v & ~set_v;

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((flags_o & $past(set_v)) == $past(set_v)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_v != '0) |=> ((flags_o & $past(keep_v)) == $past(keep_v)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_v != '0) |=> ((flags_o & $past(drop_v)) == '0));

    p_alt_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> (pin_oe_o && (pin_o == alt_out_i)));

    p_pin_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i && ((flags_o & src_en_i) != '0)) |-> (pin_oe_o && (pin_o == irq_pol_i)));

    p_pin_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i && ((flags_o & src_en_i) == '0)) |-> !pin_oe_o);

    p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld_i |-> !xing_evt);
endmodule

bind line_irq_ctrl line_irq_chk #(.NUM_EXT(NUM_EXT)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .smp_vld_i  (smp_vld_i),
    .xing_evt   (xing_evt),
    .src_en_i   (src_en_i),
    .irq_en_i   (irq_en_i),
    .irq_pol_i  (irq_pol_i),
    .alt_out_i  (alt_out_i),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .flags_o    (flags_o),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o)
);

// File: tb/test_line_irq_ctrl.sv
`timescale 1ns/1ps
module test_line_irq_ctrl;
    localparam int NE = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt = '0;
    logic          vld = 1'b0;
    logic [7:0]    volt = '0, curr = '0, thr = '0;
    logic          sel = 1'b0, dfall = 1'b0;
    logic [NE:0]   en = '0, cmask = '0;
    logic          ien = 1'b0, pol = 1'b0, alt = 1'b0, cwe = 1'b0;
    logic [NE:0]   flags;
    logic          pin, pin_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    line_irq_ctrl i_line_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .smp_vld_i(vld),
        .volt_smp_i(volt), .curr_smp_i(curr), .src_sel_i(sel), .thr_i(thr),
        .dir_fall_i(dfall), .src_en_i(en), .irq_en_i(ien), .irq_pol_i(pol),
        .alt_out_i(alt), .clr_we_i(cwe), .clr_mask_i(cmask),
        .flags_o(flags), .pin_o(pin), .pin_oe_o(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_evt(input logic [NE-1:0] e);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic clear(input logic we, input logic [NE:0] m);
        cwe = we; cmask = m;
        @(negedge clk);
        cwe = 1'b0; cmask = '0;
    endtask

    task automatic strobe(input logic [7:0] v, input logic [7:0] c);
        volt = v; curr = c; vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic t_reset;
        alt = 1'b1;
        #1;
        chk("R1 flags after reset", 32'(flags), 0);
        chk("R5 oe in alt mode", 32'(pin_oe), 1);
        chk("R5 pin follows alt", 32'(pin), 1);
    endtask

    task automatic t_ext_event;
        en = '0;
        pulse_evt(6'h04);
        chk("R2 disabled source still flags", 32'(flags), 32'h04);
        alt = 1'b0; #1;
        chk("R5 pin follows alt with flag set", 32'(pin), 0);
        chk("R5 oe stays on", 32'(pin_oe), 1);
    endtask

    task automatic t_clear;
        clear(1'b1, 7'h01);
        chk("R3 zero mask bit keeps flag", 32'(flags), 32'h04);
        clear(1'b0, 7'h04);
        chk("R3 mask without strobe ignored", 32'(flags), 32'h04);
        clear(1'b1, 7'h04);
        chk("R3 write-one clears", 32'(flags), 0);
    endtask

    task automatic t_collide;
        pulse_evt(6'h02);
        evt = 6'h02; cwe = 1'b1; cmask = 7'h02;
        @(negedge clk);
        evt = '0; cwe = 1'b0; cmask = '0;
        chk("R4 event wins over clear", 32'(flags), 32'h02);
        clear(1'b1, 7'h02);
        chk("R4 later clear works", 32'(flags), 0);
    endtask

    task automatic t_pin;
        ien = 1'b1; pol = 1'b0; en = '0;
        pulse_evt(6'h08);
        chk("R6 disabled flag releases pin", 32'(pin_oe), 0);
        en = 7'h08; #1;
        chk("R6 enabled flag drives", 32'(pin_oe), 1);
        chk("R6 active low default", 32'(pin), 0);
        pol = 1'b1; #1;
        chk("R6 active high", 32'(pin), 1);
        clear(1'b1, 7'h08);
        chk("R6 release after clear", 32'(pin_oe), 0);
        ien = 1'b0; pol = 1'b0; en = '0;
    endtask

    task automatic t_rise;
        sel = 1'b0; thr = 8'd50; dfall = 1'b0;
        strobe(8'd60, 8'd0);
        chk("R10 first strobe no event", 32'(flags), 0);
        strobe(8'd20, 8'd0);
        chk("R8 fall ignored in rising mode", 32'(flags), 0);
        strobe(8'd60, 8'd0);
        chk("R8 upward crossing", 32'(flags), 32'h40);
        clear(1'b1, 7'h40);
        strobe(8'd70, 8'd0);
        strobe(8'hC4, 8'd0);
        chk("R10 steady over no event", 32'(flags), 0);
        strobe(8'd50, 8'd0);
        chk("R7 equal is not over", 32'(flags), 0);
        strobe(8'hCD, 8'd0);
        chk("R7 magnitude of -51 crosses", 32'(flags), 32'h40);
        clear(1'b1, 7'h40);
        strobe(8'd10, 8'd0);
    endtask

    task automatic t_sel;
        sel = 1'b1; thr = 8'd126;
        strobe(8'd0, 8'h80);
        chk("R7 -128 saturates to 127", 32'(flags), 32'h40);
        clear(1'b1, 7'h40);
        thr = 8'd50;
        strobe(8'd100, 8'd0);
        chk("R7 current selected not voltage", 32'(flags), 0);
        curr = 8'd120;
        repeat (3) @(negedge clk);
        chk("R10 no strobe no event", 32'(flags), 0);
    endtask

    task automatic t_fall;
        dfall = 1'b1;
        strobe(8'd0, 8'd90);
        chk("R9 rise ignored in falling mode", 32'(flags), 0);
        strobe(8'd0, 8'hFB);
        chk("R9 downward crossing", 32'(flags), 32'h40);
        clear(1'b1, 7'h40);
        chk("R9 flag cleared", 32'(flags), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ext_event();
        t_clear();
        t_collide();
        t_pin();
        t_rise();
        t_sel();
        t_fall();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule